// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This controller walks a small processor subsystem between full-speed operation and five power-saving states. In each state it raises or drops registered enables for the CPU clock, the peripheral clock group, the real-time-clock domain and the nonvolatile memory. It also drives a CPU low-rate select, a fetch-from-RAM flag, a voltage-reference enable and a retention indication. Software asks for a state through a request port. Interrupt, event, RTC and peripheral wake inputs bring the system back, and each state accepts only its own wake sources.

Leaving either halt state goes through a stabilization interval of programmable length. During this interval the oscillator settles and the clocks stay off. The present state is always visible on a status output. Every enable comes from a flop, so the downstream clock gates never see a glitch.

Top module: `pms_seq`

## Requirements
- R1: An active-low reset, from any state, puts the sequencer in full run (mode_o = 0) with enables {cpu, lowrate, periph, rtc, nvm, vref, ram_fetch, retain} = 1,0,1,1,1,1,0,0.
- R2: The mode_o codes are: run 0, wait 1, low-power run 2, low-power wait 3, active halt 4, halt 5, stabilizing 6. The enable sets in that bit order are: wait 0,0,1,1,1,1,0,0; low-power run 1,1,1,1,0,1,1,0; low-power wait 0,1,1,1,0,1,1,0; active halt and stabilizing 0,0,0,1,0,1,0,1; halt 0,0,0,0,0,v,0,1, where v is the inverse of the reference-cut bit.
- R3: From run, a request for code 1, 2, 4 or 5 takes effect at the next edge. A request for code 0, 3, 6 or 7 is ignored, and so are all wake inputs.
- R4: From low-power run, only a request for code 0 or code 3 is accepted. Every other request and every interrupt or event input leaves the state unchanged.
- R5: Wait goes back to run on an internal interrupt, an external interrupt or a trigger event. The RTC interrupt and software requests are ignored in wait.
- R6: Low-power wait goes to low-power run, not to run, on a timer event or an I/O event. Interrupts are ignored in this state.
- R7: Active halt moves to stabilizing on an external interrupt or an RTC interrupt. Peripheral wake lines are ignored in this state.
- R8: Halt moves to stabilizing on an external interrupt, or on a peripheral wake line whose mask bit is 1. The RTC interrupt and unmasked lines are ignored.
- R9: Stabilizing lasts stab_cycles_i+1 cycles, with stab_cycles_i sampled on entry, and then enters run. Wake inputs and requests that arrive during the count are ignored.
- R10: When vref_cut_i is 1, the reference enable is low while in halt. When it is 0, the reference enable stays high in halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Software mode request strobe |
| req_mode_i | input | 3 | Requested mode code |
| irq_int_i | input | 1 | Internal interrupt |
| irq_ext_i | input | 1 | External interrupt |
| evt_trig_i | input | 1 | Trigger event |
| evt_tmr_i | input | 1 | Timer event |
| evt_io_i | input | 1 | I/O line event |
| rtc_irq_i | input | 1 | RTC interrupt |
| pwake_i | input | NPERIPH | Peripheral wake requests |
| pwake_mask_i | input | NPERIPH | Per-peripheral halt wake enable |
| vref_cut_i | input | 1 | Drop the reference enable during halt |
| stab_cycles_i | input | CNT_W | Stabilization length minus one |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| cpu_lowrate_o | output | 1 | CPU reduced-rate select |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| rtc_clk_en_o | output | 1 | RTC clock enable |
| nvm_en_o | output | 1 | Nonvolatile memory enable |
| vref_en_o | output | 1 | Voltage reference enable |
| ram_fetch_o | output | 1 | Code runs from RAM |
| retain_o | output | 1 | Retention power indication |
| mode_o | output | 3 | Current mode code |

## Verification
The assertions assume that reset is driven to a known level from time zero. They also assume that the wake and request inputs change only between clock edges, so one sampled value decides each transition. The stimulus drives every input on the falling edge and holds stab_cycles_i and vref_cut_i constant while the sequencer is in a halt or stabilizing state. Because of that, the length sampled on entry and the reference setting stay the same for the whole interval being checked.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    PM_RUN    = 3'd0,
    PM_WAIT   = 3'd1,
    PM_LPRUN  = 3'd2,
    PM_LPWAIT = 3'd3,
    PM_AHALT  = 3'd4,
    PM_HALT   = 3'd5,
    PM_STAB   = 3'd6
  } pm_state_e;

  typedef struct packed {
    logic cpu;
    logic lowrate;
    logic periph;
    logic rtc;
    logic nvm;
    logic vref;
    logic ram_fetch;
    logic retain;
  } clk_prof_t;

  // enable set that belongs to each state
  function automatic clk_prof_t profile_of(pm_state_e s, logic vref_cut);
    clk_prof_t p;
    p = '{cpu:1'b1, lowrate:1'b0, periph:1'b1, rtc:1'b1,
          nvm:1'b1, vref:1'b1, ram_fetch:1'b0, retain:1'b0};
    case (s)
      PM_WAIT:   p.cpu = 1'b0;
      PM_LPRUN: begin
        p.lowrate = 1'b1; p.nvm = 1'b0; p.ram_fetch = 1'b1;
      end
      PM_LPWAIT: begin
        p.cpu = 1'b0; p.lowrate = 1'b1; p.nvm = 1'b0; p.ram_fetch = 1'b1;
      end
      PM_AHALT, PM_STAB: begin
        p.cpu = 1'b0; p.periph = 1'b0; p.nvm = 1'b0; p.retain = 1'b1;
      end
      PM_HALT: begin
        p.cpu = 1'b0; p.periph = 1'b0; p.rtc = 1'b0; p.nvm = 1'b0;
        p.vref = ~vref_cut; p.retain = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

  // which software requests a state honours
  function automatic logic req_allowed(pm_state_e cur, logic [2:0] tgt);
    logic ok;
    ok = 1'b0;
    case (cur)
      PM_RUN:   ok = (tgt == PM_WAIT) || (tgt == PM_LPRUN) ||
                     (tgt == PM_AHALT) || (tgt == PM_HALT);
      PM_LPRUN: ok = (tgt == PM_RUN) || (tgt == PM_LPWAIT);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pms_wake_qual.sv
module pms_wake_qual
  import pms_pkg::*;
#(
  parameter int NPERIPH = 4
) (
  input  pm_state_e          state,
  input  logic               irq_int,
  input  logic               irq_ext,
  input  logic               evt_trig,
  input  logic               evt_tmr,
  input  logic               evt_io,
  input  logic               rtc_irq,
  input  logic [NPERIPH-1:0] pwake,
  input  logic [NPERIPH-1:0] pwake_mask,
  output logic               wake_hit,
  output pm_state_e          wake_dest
);

  logic pwake_any;
  assign pwake_any = |(pwake & pwake_mask);

  always_comb begin
    wake_hit  = 1'b0;
    wake_dest = PM_RUN;
    case (state)
      PM_WAIT: begin
        wake_hit  = irq_int | irq_ext | evt_trig;
        wake_dest = PM_RUN;
      end
      PM_LPWAIT: begin
        wake_hit  = evt_tmr | evt_io;
        wake_dest = PM_LPRUN;
      end
      PM_AHALT: begin
        wake_hit  = irq_ext | rtc_irq;
        wake_dest = PM_STAB;
      end
      PM_HALT: begin
        wake_hit  = irq_ext | pwake_any;
        wake_dest = PM_STAB;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pms_stab_timer.sv
module pms_stab_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/pms_clk_reg.sv
module pms_clk_reg
  import pms_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pm_state_e state_d,
  input  logic      vref_cut,
  output clk_prof_t prof_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prof_q <= profile_of(PM_RUN, 1'b0);
    else        prof_q <= profile_of(state_d, vref_cut);
  end

endmodule

// File: rtl/pms_seq.sv
module pms_seq
  import pms_pkg::*;
#(
  parameter int NPERIPH = 4,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  input  logic [2:0]         req_mode_i,
  input  logic               irq_int_i,
  input  logic               irq_ext_i,
  input  logic               evt_trig_i,
  input  logic               evt_tmr_i,
  input  logic               evt_io_i,
  input  logic               rtc_irq_i,
  input  logic [NPERIPH-1:0] pwake_i,
  input  logic [NPERIPH-1:0] pwake_mask_i,
  input  logic               vref_cut_i,
  input  logic [CNT_W-1:0]   stab_cycles_i,
  output logic               cpu_clk_en_o,
  output logic               cpu_lowrate_o,
  output logic               periph_clk_en_o,
  output logic               rtc_clk_en_o,
  output logic               nvm_en_o,
  output logic               vref_en_o,
  output logic               ram_fetch_o,
  output logic               retain_o,
  output logic [2:0]         mode_o
);

  pm_state_e state_q, state_d, wake_dest;
  logic      wake_hit, req_ok, stab_load, stab_run, stab_done;
  clk_prof_t prof_q;

  assign req_ok = req_valid_i && req_allowed(state_q, req_mode_i);

  pms_wake_qual #(.NPERIPH(NPERIPH)) u_wake (
    .state(state_q), .irq_int(irq_int_i), .irq_ext(irq_ext_i),
    .evt_trig(evt_trig_i), .evt_tmr(evt_tmr_i), .evt_io(evt_io_i),
    .rtc_irq(rtc_irq_i), .pwake(pwake_i), .pwake_mask(pwake_mask_i),
    .wake_hit(wake_hit), .wake_dest(wake_dest)
  );

  always_comb begin
    state_d = state_q;
    if (state_q == PM_STAB) begin
      if (stab_done) state_d = PM_RUN;
    end else if (req_ok) begin
      state_d = pm_state_e'(req_mode_i);
    end else if (wake_hit) begin
      state_d = wake_dest;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  assign stab_load = (state_q != PM_STAB) && (state_d == PM_STAB);
  assign stab_run  = (state_q == PM_STAB);

  pms_stab_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(stab_load), .run(stab_run),
    .load_val(stab_cycles_i), .done(stab_done)
  );

  pms_clk_reg u_clkreg (
    .clk(clk), .rst_n(rst_n), .state_d(state_d),
    .vref_cut(vref_cut_i), .prof_q(prof_q)
  );

  assign cpu_clk_en_o    = prof_q.cpu;
  assign cpu_lowrate_o   = prof_q.lowrate;
  assign periph_clk_en_o = prof_q.periph;
  assign rtc_clk_en_o    = prof_q.rtc;
  assign nvm_en_o        = prof_q.nvm;
  assign vref_en_o       = prof_q.vref;
  assign ram_fetch_o     = prof_q.ram_fetch;
  assign retain_o        = prof_q.retain;
  assign mode_o          = state_q;

endmodule

// File: rtl/pms_checker.sv
module pms_checker #(
  parameter int NPERIPH = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid_i,
  input logic               irq_ext_i,
  input logic               evt_tmr_i,
  input logic               evt_io_i,
  input logic               rtc_irq_i,
  input logic [NPERIPH-1:0] pwake_i,
  input logic [NPERIPH-1:0] pwake_mask_i,
  input logic               stab_done,
  input logic               cpu_clk_en_o,
  input logic               periph_clk_en_o,
  input logic               rtc_clk_en_o,
  input logic               nvm_en_o,
  input logic               retain_o,
  input logic [2:0]         mode_o
);

  // R1
  reset_to_run_chk: assert property (@(posedge clk)
    !rst_n |=> (mode_o == 3'd0 && cpu_clk_en_o && nvm_en_o));

  // R2
  wait_profile_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 3'd1 |-> (!cpu_clk_en_o && periph_clk_en_o));

  // R4
  lprun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2 && !req_valid_i) |=> mode_o == 3'd2);

  // R6
  lpwait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 && (evt_tmr_i || evt_io_i)) |=> mode_o == 3'd2);

  // R7
  ahalt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && (irq_ext_i || rtc_irq_i)) |=> mode_o == 3'd6);

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5 && !irq_ext_i && ((pwake_i & pwake_mask_i) == '0))
    |=> mode_o == 3'd5);

  // R8
  halt_profile_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 3'd5 |-> (!rtc_clk_en_o && !periph_clk_en_o && retain_o));

  // R9
  stab_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd6 && !stab_done) |=> mode_o == 3'd6);

  // R9
  stab_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd6 && stab_done) |=> (mode_o == 3'd0 && cpu_clk_en_o));

endmodule

bind pms_seq pms_checker #(.NPERIPH(NPERIPH)) u_pms_checker (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i),
  .irq_ext_i(irq_ext_i), .evt_tmr_i(evt_tmr_i), .evt_io_i(evt_io_i),
  .rtc_irq_i(rtc_irq_i), .pwake_i(pwake_i), .pwake_mask_i(pwake_mask_i),
  .stab_done(stab_done), .cpu_clk_en_o(cpu_clk_en_o),
  .periph_clk_en_o(periph_clk_en_o), .rtc_clk_en_o(rtc_clk_en_o),
  .nvm_en_o(nvm_en_o), .retain_o(retain_o), .mode_o(mode_o)
);

// File: tb/pms_seq_bench.sv
module pms_seq_bench;

  localparam int NP = 4;
  localparam int CW = 8;

  // enables packed {cpu, lowrate, periph, rtc, nvm, vref, ram_fetch, retain}
  localparam logic [7:0] E_RUN  = 8'b1011_1100;
  localparam logic [7:0] E_WAIT = 8'b0011_1100;
  localparam logic [7:0] E_LPR  = 8'b1111_0110;
  localparam logic [7:0] E_LPW  = 8'b0111_0110;
  localparam logic [7:0] E_AH   = 8'b0001_0101;
  localparam logic [7:0] E_HALT = 8'b0000_0101;
  localparam logic [7:0] E_HCUT = 8'b0000_0001;
  localparam logic [7:0] E_ST   = 8'b0001_0101;

  // wake bits {int, ext, trig, tmr, io, rtc}
  localparam logic [5:0] W0 = 6'b000000, WI = 6'b100000, WE = 6'b010000,
                         WT = 6'b001000, WM = 6'b000100, WO = 6'b000010,
                         WR = 6'b000001;

  function automatic logic [24:0] mk(logic rv, logic [2:0] rm, logic [5:0] w,
                                     logic [3:0] pw, logic [2:0] em,
                                     logic [7:0] ee);
    return {rv, rm, w, pw, em, ee};
  endfunction

  localparam int NV = 38;
  localparam logic [24:0] VEC [NV] = '{
    mk(0,0,W0,0,0,E_RUN),        // R1 idle
    mk(0,0,WI,0,0,E_RUN),        // R3 wake ignored in run
    mk(1,3,W0,0,0,E_RUN),        // R3 req 3 ignored
    mk(1,1,W0,0,1,E_WAIT),       // R3 -> wait
    mk(0,0,WR,0,1,E_WAIT),       // R5 rtc ignored
    mk(1,0,W0,0,1,E_WAIT),       // R5 request ignored
    mk(0,0,WT,0,0,E_RUN),        // R5 trigger exits
    mk(1,2,W0,0,2,E_LPR),        // R3 -> lp run
    mk(0,0,WI|WE,0,2,E_LPR),     // R4 irqs ignored
    mk(1,5,W0,0,2,E_LPR),        // R4 halt req ignored
    mk(1,3,W0,0,3,E_LPW),        // R4 -> lp wait
    mk(0,0,WI,0,3,E_LPW),        // R6 irq ignored
    mk(0,0,WM,0,2,E_LPR),        // R6 timer -> lp run
    mk(1,3,W0,0,3,E_LPW),        // R4
    mk(0,0,WO,0,2,E_LPR),        // R6 io -> lp run
    mk(1,0,W0,0,0,E_RUN),        // R4 back to run
    mk(1,4,W0,0,4,E_AH),         // R3 -> active halt
    mk(0,0,W0,4'b0001,4,E_AH),   // R7 periph ignored
    mk(0,0,WR,0,6,E_ST),         // R7 rtc wake
    mk(0,0,WE,0,6,E_ST),         // R9 ignored during count
    mk(0,0,W0,0,6,E_ST),         // R9
    mk(0,0,W0,0,0,E_RUN),        // R9 count over
    mk(1,5,W0,0,5,E_HALT),       // R3 -> halt
    mk(0,0,WR,0,5,E_HALT),       // R8 rtc ignored
    mk(0,0,W0,4'b0010,5,E_HALT), // R8 unmasked line
    mk(0,0,W0,4'b0100,6,E_ST),   // R8 masked-in line
    mk(0,0,W0,0,6,E_ST),         // R9
    mk(0,0,W0,0,6,E_ST),         // R9
    mk(0,0,W0,0,0,E_RUN),        // R9
    mk(1,1,W0,0,1,E_WAIT),       // R5
    mk(0,0,WE,0,0,E_RUN),        // R5 ext exits
    mk(1,5,W0,0,5,E_HALT),       // R8
    mk(0,0,WE,0,6,E_ST),         // R8 ext wake
    mk(1,1,W0,0,6,E_ST),         // R9 request ignored
    mk(0,0,W0,0,6,E_ST),         // R9
    mk(0,0,W0,0,0,E_RUN),        // R9
    mk(1,6,W0,0,0,E_RUN),        // R3 code 6 ignored
    mk(1,7,W0,0,0,E_RUN)         // R3 code 7 ignored
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, irq_int = 0, irq_ext = 0, evt_trig = 0, evt_tmr = 0;
  logic evt_io = 0, rtc_irq = 0, vref_cut = 0;
  logic [2:0] req_mode = '0;
  logic [NP-1:0] pwake = '0, pwake_mask = 4'b0101;
  logic [CW-1:0] stab_cycles = 8'd2;
  logic cpu, lowr, per, rtc, nvm, vref, ramf, ret;
  logic [2:0] mode;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pms_seq #(.NPERIPH(NP), .CNT_W(CW)) u_pms_seq (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .irq_int_i(irq_int), .irq_ext_i(irq_ext), .evt_trig_i(evt_trig),
    .evt_tmr_i(evt_tmr), .evt_io_i(evt_io), .rtc_irq_i(rtc_irq),
    .pwake_i(pwake), .pwake_mask_i(pwake_mask), .vref_cut_i(vref_cut),
    .stab_cycles_i(stab_cycles), .cpu_clk_en_o(cpu), .cpu_lowrate_o(lowr),
    .periph_clk_en_o(per), .rtc_clk_en_o(rtc), .nvm_en_o(nvm),
    .vref_en_o(vref), .ram_fetch_o(ramf), .retain_o(ret), .mode_o(mode)
  );

  task automatic chk(string tag, logic [2:0] em, logic [7:0] ee);
    logic [10:0] got;
    got = {mode, cpu, lowr, per, rtc, nvm, vref, ramf, ret};
    checks++;
    if (got !== {em, ee}) begin
      errors++;
      $display("FAIL %s: mode/en got %0d/%b expected %0d/%b",
               tag, got[10:8], got[7:0], em, ee);
    end
  endtask

  task automatic drive(logic rv, logic [2:0] rm, logic [5:0] w, logic [3:0] pw);
    req_valid = rv; req_mode = rm;
    {irq_int, irq_ext, evt_trig, evt_tmr, evt_io, rtc_irq} = w;
    pwake = pw;
  endtask

  task automatic step(logic rv, logic [2:0] rm, logic [5:0] w, logic [3:0] pw);
    drive(rv, rm, w, pw);
    @(negedge clk);
    drive(0, 0, W0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 3'd0, E_RUN);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][24], VEC[i][23:21], VEC[i][20:15], VEC[i][14:11]);
      chk($sformatf("R2 vector %0d", i), VEC[i][10:8], VEC[i][7:0]);
    end

    // R10 reference cut in halt, then normal return
    vref_cut = 1'b1;
    step(1, 5, W0, 0);  chk("R10 halt ref cut", 3'd5, E_HCUT);
    step(0, 0, WE, 0);  chk("R10 stab after cut", 3'd6, E_ST);
    step(0, 0, W0, 0);  step(0, 0, W0, 0);
    step(0, 0, W0, 0);  chk("R10 run restored", 3'd0, E_RUN);
    vref_cut = 1'b0;

    // R9 zero-length count: one stabilizing cycle
    stab_cycles = 8'd0;
    step(1, 4, W0, 0);  step(0, 0, WR, 0);
    chk("R9 zero count entry", 3'd6, E_ST);
    step(0, 0, W0, 0);  chk("R9 zero count exit", 3'd0, E_RUN);

    // R9 long count of 10
    stab_cycles = 8'd10;
    step(1, 5, W0, 0);  step(0, 0, W0, 4'b0001);
    for (int k = 0; k < 10; k++) step(0, 0, WE, 0);
    chk("R9 still counting", 3'd6, E_ST);
    step(0, 0, W0, 0);  chk("R9 long exit", 3'd0, E_RUN);

    // R1 reset from low-power run and during stabilizing
    step(1, 2, W0, 0);  chk("R1 pre lp run", 3'd2, E_LPR);
    #3 rst_n = 1'b0;
    @(negedge clk);     chk("R1 reset from lp run", 3'd0, E_RUN);
    rst_n = 1'b1;
    step(1, 4, W0, 0);  step(0, 0, WR, 0);
    chk("R1 pre stab", 3'd6, E_ST);
    #3 rst_n = 1'b0;
    @(negedge clk);     chk("R1 reset from stab", 3'd0, E_RUN);
    rst_n = 1'b1;
    step(0, 0, W0, 0);  chk("R1 stays run", 3'd0, E_RUN);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule